// File: doc/BRIEF.md
# Eight-Channel Block Copy Engine

This block moves bytes between a 24-bit memory-side address space (the A side) and a 256-entry peripheral register window (the B side). Each of its eight channels has a direction, a bank and a 16-bit address, fixed or reverse stepping, a three-bit offset pattern mode, a 16-bit byte count and a base offset into the B window. A single `start` pulse latches the set of enabled channels. The engine then serves them from the lowest number to the highest, and each channel runs to the end before the next one begins.

Every byte is one step. In that step the engine reads the current byte from the source side and writes the byte read in the previous step to the destination side. A flush step at the end of each channel drains the last pending write. Accesses that target the block's own register regions, and memory-to-memory copies that would need the one A-side address bus twice, are suppressed. Such an access still costs its step. A separate table-driven engine can abort any channel through the `abort` input. When the last channel is finished the engine raises `done` for one cycle.

Configuration inputs other than `cfg_en` must stay stable while `busy` is high. `cfg_en` is sampled only when a run starts.

Top module: `blkdma`

## Requirements
- R1: A `start` seen while idle latches `cfg_en` into `chan_en` and raises `busy`. The enabled channels are then served in ascending number, and every byte of a channel is written before the first byte of the next channel.
- R2: The B offset of byte index i is `cfg_boff` plus a term chosen by `cfg_mode` (3-bit code). The term is 0 for codes 0, 2 and 6, i mod 2 for codes 1 and 5, bit 1 of i for codes 3 and 7, and i mod 4 for code 4. The sum wraps at 8 bits.
- R3: After each byte the low 16 bits of the A address rise by one, or fall by one when `cfg_rev` is 1. They stay unchanged when `cfg_fixed` is 1, whatever `cfg_rev` is. The 8-bit bank never changes and the 16-bit part wraps.
- R4: A channel moves `cfg_count` bytes, and a count of 0 moves 65536 bytes.
- R5: The write of byte N happens in the same cycle as the read of byte N+1, and each channel ends with one flush step. A run therefore lasts 1 + Σ(bytes+1) cycles from the cycle after `start` is sampled, and `done` is high in the cycle after the last step.
- R6: An A address with bank bit 6 clear whose low 16 bits lie in 0x2100–0x21FF, 0x4000–0x421F or 0x4300–0x437F is never strobed. A read there yields data 0x00, and a write there is dropped.
- R7: When the B offset is 0x80 and the A address lies in bank 0x7E or 0x7F, or has bank bit 6 clear and address bits 15:13 all zero, the B-side access is suppressed. With direction 0 the B write is dropped. With direction 1 the B read is skipped and the value 0x00 is carried to the A write.
- R8: With `cfg_dir` = 0, data flows from the A side to the B side. With `cfg_dir` = 1 it flows from the B side to the A side. On a given bus a read and a write never occur in the same cycle.
- R9: A channel's `chan_en` bit clears when the channel finishes. `done` is a single-cycle pulse with `busy` low and `chan_en` all zero.
- R10: An `abort` bit seen at a clock edge clears that channel's `chan_en` bit. A running channel stops after the byte in progress and then flushes. A channel that has not yet started is skipped.
- R11: A `start` seen while `busy` is high has no effect on the run, on `chan_en` or on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| cfg_en | input | NCH | Channel enables, sampled at start |
| cfg_dir | input | NCH | 0: A to B, 1: B to A |
| cfg_fixed | input | NCH | Hold A address |
| cfg_rev | input | NCH | Step A address downward |
| cfg_mode | input | 3*NCH | B offset pattern code per channel |
| cfg_bank | input | 8*NCH | A bank per channel |
| cfg_boff | input | 8*NCH | B base offset per channel |
| cfg_addr | input | 16*NCH | A start address per channel |
| cfg_count | input | CW*NCH | Byte count per channel (0 = 2^CW) |
| abort | input | NCH | Stop channel at next byte boundary |
| a_addr | output | 24 | A-side address |
| a_rd | output | 1 | A-side read strobe |
| a_wr | output | 1 | A-side write strobe |
| a_wdata | output | 8 | A-side write data |
| a_rdata | input | 8 | A-side read data, same cycle |
| b_addr | output | 8 | B-side register offset |
| b_rd | output | 1 | B-side read strobe |
| b_wr | output | 1 | B-side write strobe |
| b_wdata | output | 8 | B-side write data |
| b_rdata | input | 8 | B-side read data, same cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| chan_en | output | NCH | Live channel enables |

## Verification
The checker watches every cycle for strobes into the guarded register regions on the A side, for a read and a write on the same bus in the same cycle, and for writes that appear outside a run. It also checks that `done` lasts one cycle and arrives with `busy` low and every enable cleared. Channel order, the offset patterns, address stepping, the one-step write lag, the bus-to-bus suppression and the exact run length are seen only in the bench. The bench compares the complete write stream and the cycle of `done` against a model, using random and directed configurations, an abort scenario, a mid-run start and a 65536-byte channel.

// File: rtl/blkdma.sv
module blkdma #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCH-1:0]    cfg_en,
  input  logic [NCH-1:0]    cfg_dir,
  input  logic [NCH-1:0]    cfg_fixed,
  input  logic [NCH-1:0]    cfg_rev,
  input  logic [3*NCH-1:0]  cfg_mode,
  input  logic [8*NCH-1:0]  cfg_bank,
  input  logic [8*NCH-1:0]  cfg_boff,
  input  logic [16*NCH-1:0] cfg_addr,
  input  logic [CW*NCH-1:0] cfg_count,
  input  logic [NCH-1:0]    abort,
  output logic [23:0]       a_addr,
  output logic              a_rd,
  output logic              a_wr,
  output logic [7:0]        a_wdata,
  input  logic [7:0]        a_rdata,
  output logic [7:0]        b_addr,
  output logic              b_rd,
  output logic              b_wr,
  output logic [7:0]        b_wdata,
  input  logic [7:0]        b_rdata,
  output logic              busy,
  output logic              done,
  output logic [NCH-1:0]    chan_en
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_HEAD, S_XFER, S_FLUSH} st_t;

  st_t             st;
  logic [IW-1:0]   ch, nxt;
  logic            found;
  logic [15:0]     ptr;
  logic [CW-1:0]   cnt;
  logic [1:0]      idx;
  logic [NCH-1:0]  en, en_live;
  logic            pv, pto_a;
  logic [23:0]     paddr;
  logic [7:0]      pdata;
  logic            done_q;

  function automatic logic in_hole(input logic [23:0] a);
    return !a[22] && (a[15:8] == 8'h21 || a[15:9] == 7'h20 ||
                      a[15:5] == 11'h210 || a[15:7] == 9'h086);
  endfunction

  logic        dir_c;
  logic [2:0]  mode_c;
  logic [7:0]  bank_c, boff_c, off;
  logic [1:0]  term;
  logic [23:0] cur_a;
  logic        av, xv;
  logic [7:0]  rdat;
  logic        wr_go, last;

  assign dir_c  = cfg_dir[ch];
  assign mode_c = cfg_mode[ch*3 +: 3];
  assign bank_c = cfg_bank[ch*8 +: 8];
  assign boff_c = cfg_boff[ch*8 +: 8];
  assign cur_a  = {bank_c, ptr};

  always_comb begin
    case (mode_c)
      3'd1, 3'd5: term = {1'b0, idx[0]};
      3'd3, 3'd7: term = {1'b0, idx[1]};
      3'd4:       term = idx;
      default:    term = 2'd0;
    endcase
  end

  assign off  = boff_c + {6'd0, term};
  assign av   = !in_hole(cur_a);
  assign xv   = !(off == 8'h80 && (cur_a[23:17] == 7'h3F ||
                                   (!cur_a[22] && cur_a[15:13] == 3'd0)));
  assign rdat = dir_c ? (xv ? b_rdata : 8'h00) : (av ? a_rdata : 8'h00);

  assign en_live = en & ~abort;

  always_comb begin
    found = 1'b0;
    nxt   = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (en_live[i]) begin
        found = 1'b1;
        nxt   = IW'(i);
      end
  end

  assign wr_go   = (st == S_XFER || st == S_FLUSH) && pv;
  assign a_wr    = wr_go && pto_a;
  assign b_wr    = wr_go && !pto_a;
  assign a_rd    = (st == S_XFER) && !dir_c && av;
  assign b_rd    = (st == S_XFER) && dir_c && xv;
  assign a_addr  = a_wr ? paddr : cur_a;
  assign b_addr  = b_wr ? paddr[7:0] : off;
  assign a_wdata = pdata;
  assign b_wdata = pdata;
  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign chan_en = en;
  assign last    = (cnt == CW'(1)) || !en_live[ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ch     <= '0;
      ptr    <= '0;
      cnt    <= '0;
      idx    <= '0;
      en     <= '0;
      pv     <= 1'b0;
      pto_a  <= 1'b0;
      paddr  <= '0;
      pdata  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          pv <= 1'b0;
          if (start) begin
            en <= cfg_en;
            st <= S_HEAD;
          end else begin
            en <= en_live;
          end
        end
        S_HEAD, S_FLUSH: begin
          pv <= 1'b0;
          en <= en_live;
          if (found) begin
            ch  <= nxt;
            ptr <= cfg_addr[nxt*16 +: 16];
            cnt <= cfg_count[nxt*CW +: CW];
            idx <= '0;
            st  <= S_XFER;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        S_XFER: begin
          pv    <= dir_c ? av : xv;
          pto_a <= dir_c;
          paddr <= dir_c ? cur_a : {16'd0, off};
          pdata <= rdat;
          if (!cfg_fixed[ch]) ptr <= cfg_rev[ch] ? ptr - 16'd1 : ptr + 16'd1;
          cnt <= cnt - CW'(1);
          idx <= idx + 2'd1;
          if (last) begin
            st <= S_FLUSH;
            en <= en_live & ~(NCH'(1) << ch);
          end else begin
            en <= en_live;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           a_rd,
  input logic           a_wr,
  input logic           b_rd,
  input logic           b_wr,
  input logic [23:0]    a_addr,
  input logic [NCH-1:0] chan_en
);
  logic guarded;
  always_comb begin
    guarded = 1'b0;
    if (a_addr[22] == 1'b0) begin
      if (a_addr[15:0] >= 16'h2100 && a_addr[15:0] <= 16'h21FF) guarded = 1'b1;
      if (a_addr[15:0] >= 16'h4000 && a_addr[15:0] <= 16'h421F) guarded = 1'b1;
      if (a_addr[15:0] >= 16'h4300 && a_addr[15:0] <= 16'h437F) guarded = 1'b1;
    end
  end

  a_r6_no_guarded_read: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd |-> !guarded);
  a_r6_no_guarded_write: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr |-> !guarded);
  a_r8_one_way_per_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_rd && a_wr) && !(b_rd && b_wr));
  a_r5_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr || b_wr) |-> busy && $past(busy));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && chan_en == '0);
endmodule

bind blkdma blkdma_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .a_rd(a_rd), .a_wr(a_wr), .b_rd(b_rd), .b_wr(b_wr),
  .a_addr(a_addr), .chan_en(chan_en)
);

// File: tb/blkdma_bench.sv
module blkdma_bench;
  localparam int NCH = 8;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NCH-1:0]    cfg_en = '0, cfg_dir = '0, cfg_fixed = '0, cfg_rev = '0, abort = '0;
  logic [3*NCH-1:0]  cfg_mode = '0;
  logic [8*NCH-1:0]  cfg_bank = '0, cfg_boff = '0;
  logic [16*NCH-1:0] cfg_addr = '0;
  logic [CW*NCH-1:0] cfg_count = '0;
  logic [23:0] a_addr;
  logic a_rd, a_wr, b_rd, b_wr, busy, done;
  logic [7:0] a_wdata, a_rdata, b_addr, b_wdata, b_rdata;
  logic [NCH-1:0] chan_en;

  always #2 clk = ~clk;

  function automatic logic [7:0] fa(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] fb(input logic [7:0] o);
    return o * 8'd3 + 8'd1;
  endfunction
  assign a_rdata = fa(a_addr);
  assign b_rdata = fb(b_addr);

  blkdma #(.NCH(NCH), .CW(CW)) u_blkdma (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
    .cfg_fixed(cfg_fixed), .cfg_rev(cfg_rev), .cfg_mode(cfg_mode), .cfg_bank(cfg_bank),
    .cfg_boff(cfg_boff), .cfg_addr(cfg_addr), .cfg_count(cfg_count), .abort(abort),
    .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .busy(busy), .done(done), .chan_en(chan_en)
  );

  int errors = 0, checks = 0, cyc = 0, bad_rd = 0;
  logic [32:0] exp_q[$], obs_q[$];
  int lim[NCH];

  task automatic chk(input logic ok, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic a_ok(input logic [23:0] a);
    logic [15:0] lo = a[15:0];
    if (a[22]) return 1'b1;
    return !((lo >= 16'h2100 && lo <= 16'h21FF) || (lo >= 16'h4000 && lo <= 16'h421F) ||
             (lo >= 16'h4300 && lo <= 16'h437F));
  endfunction
  function automatic logic x_ok(input logic [7:0] o, input logic [23:0] a);
    return !(o == 8'h80 && (a[23:16] == 8'h7E || a[23:16] == 8'h7F ||
                            (!a[22] && a[15:13] == 3'd0)));
  endfunction
  function automatic logic [7:0] pat(input logic [2:0] m, input int i);
    case (m)
      3'd1, 3'd5: return 8'(i % 2);
      3'd3, 3'd7: return 8'((i / 2) % 2);
      3'd4:       return 8'(i % 4);
      default:    return 8'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (a_wr) obs_q.push_back({1'b1, a_addr, a_wdata});
    if (b_wr) obs_q.push_back({1'b0, 16'd0, b_addr, b_wdata});
    if (a_rd && !a_ok(a_addr)) bad_rd++;
  end

  task automatic build_exp(output int tot);
    exp_q.delete();
    tot = 1;
    for (int c = 0; c < NCH; c++) begin
      logic [15:0] p = cfg_addr[c*16 +: 16];
      logic [7:0]  bk = cfg_bank[c*8 +: 8];
      if (lim[c] == 0) continue;
      tot += lim[c] + 1;
      for (int j = 0; j < lim[c]; j++) begin
        logic [23:0] a = {bk, p};
        logic [7:0]  o = cfg_boff[c*8 +: 8] + pat(cfg_mode[c*3 +: 3], j);
        logic [7:0]  d;
        if (!cfg_dir[c]) begin
          d = a_ok(a) ? fa(a) : 8'h00;
          if (x_ok(o, a)) exp_q.push_back({1'b0, 16'd0, o, d});
        end else begin
          d = x_ok(o, a) ? fb(o) : 8'h00;
          if (a_ok(a)) exp_q.push_back({1'b1, a, d});
        end
        if (!cfg_fixed[c]) p = cfg_rev[c] ? p - 16'd1 : p + 16'd1;
      end
    end
  endtask

  task automatic lim_from_cfg();
    for (int c = 0; c < NCH; c++) begin
      int n = int'(cfg_count[c*CW +: CW]);
      lim[c] = cfg_en[c] ? (n == 0 ? 65536 : n) : 0;
    end
  endtask

  task automatic setch(input int c, input logic en, input logic dir, input logic [7:0] bank,
                       input logic [15:0] addr, input logic fx, input logic rv,
                       input logic [2:0] mode, input logic [15:0] count, input logic [7:0] boff);
    cfg_en[c] = en; cfg_dir[c] = dir; cfg_bank[c*8 +: 8] = bank; cfg_addr[c*16 +: 16] = addr;
    cfg_fixed[c] = fx; cfg_rev[c] = rv; cfg_mode[c*3 +: 3] = mode;
    cfg_count[c*CW +: CW] = count; cfg_boff[c*8 +: 8] = boff;
  endtask

  task automatic compare(input string tag);
    int mism = -1;
    chk(obs_q.size() == exp_q.size(), {tag, " write count"}, obs_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
      if (obs_q[i] !== exp_q[i] && mism < 0) mism = i;
    chk(mism < 0, {tag, " write stream"}, mism < 0 ? 0 : obs_q[mism], mism < 0 ? 0 : exp_q[mism]);
  endtask

  task automatic run(input logic restart, input string tag);
    int tot, k;
    logic [NCH-1:0] saved = cfg_en;
    lim_from_cfg();
    build_exp(tot);
    obs_q.delete();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    if (k == 1) chk(busy && chan_en == saved, "R1 busy and enables latched", {busy, chan_en}, {1'b1, saved});
    while (!done && k < 70000) begin
      if (restart && k == 3) begin start = 1'b1; cfg_en = ~saved; end
      else if (restart && k == 4) begin start = 1'b0; cfg_en = saved; end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    cfg_en = saved;
    compare({tag, " R1/R2/R3/R7/R8"});
    chk(k == tot + 1, {tag, " R5 run length", restart ? " R11" : ""}, k, tot + 1);
    chk(chan_en == '0 && !busy, {tag, " R9 enables cleared"}, chan_en, 0);
    @(negedge clk);
    chk(!done, {tag, " R9 done single cycle"}, done, 0);
  endtask

  logic [7:0]  bank_pick[7] = '{8'h00, 8'h7E, 8'h7F, 8'h40, 8'h80, 8'hC0, 8'h01};
  logic [15:0] addr_pick[9] = '{16'h20FE, 16'h21FE, 16'h41FE, 16'h421E, 16'h437E,
                                16'h1FFE, 16'hFFFE, 16'h0001, 16'h8000};

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && chan_en == '0 && !a_wr && !b_wr && !a_rd && !b_rd,
        "reset state", {busy, done, chan_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 / R7 / R3 directed
    cfg_en = '0;
    setch(1, 1, 0, 8'h00, 16'h20FF, 0, 0, 3'd0, 16'd3, 8'h18);
    setch(3, 1, 0, 8'h7E, 16'h0010, 0, 0, 3'd0, 16'd2, 8'h80);
    setch(5, 1, 1, 8'h00, 16'h1FFF, 0, 1, 3'd1, 16'd3, 8'h7F);
    setch(6, 1, 1, 8'h80, 16'h437F, 0, 1, 3'd4, 16'd3, 8'h10);
    setch(7, 1, 0, 8'h40, 16'h2100, 1, 1, 3'd3, 16'd5, 8'hFE);
    run(1'b0, "directed guards R6");
    chk(bad_rd == 0, "R6 no read strobe in guarded region", bad_rd, 0);

    // no channels enabled
    cfg_en = '0;
    run(1'b0, "empty run R5");

    // R10 abort
    cfg_en = '0;
    setch(0, 1, 0, 8'h7E, 16'h1000, 0, 0, 3'd1, 16'd10, 8'h10);
    setch(1, 1, 1, 8'hC0, 16'h0500, 0, 1, 3'd4, 16'd4, 8'h20);
    setch(2, 1, 0, 8'h00, 16'h8000, 0, 0, 3'd0, 16'd5, 8'h30);
    begin
      int k, tot;
      lim[0] = 3; lim[1] = 4;
      for (int c = 2; c < NCH; c++) lim[c] = 0;
      build_exp(tot);
      obs_q.delete();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 1;
      while (!done && k < 1000) begin
        if (k == 4) abort = 8'b0000_0101;
        if (k == 5) begin
          abort = '0;
          chk(chan_en == 8'b0000_0010, "R10 abort clears enables", chan_en, 8'b0000_0010);
        end
        @(negedge clk);
        k++;
      end
      compare("abort R10");
      chk(k == tot + 1, "R10 abort run length", k, tot + 1);
      @(negedge clk);
    end

    // random runs, with a start pulse mid-run on odd runs (R11)
    for (int r = 0; r < 30; r++) begin
      for (int c = 0; c < NCH; c++)
        setch(c, $urandom_range(0, 2) != 0, $urandom_range(0, 1),
              ($urandom_range(0, 3) == 0) ? 8'($urandom) : bank_pick[$urandom_range(0, 6)],
              ($urandom_range(0, 3) == 0) ? 16'($urandom) : addr_pick[$urandom_range(0, 8)],
              $urandom_range(0, 3) == 0, $urandom_range(0, 1), 3'($urandom_range(0, 7)),
              16'($urandom_range(1, 6)),
              ($urandom_range(0, 2) == 0) ? 8'h80 : (($urandom_range(0, 1) == 0) ? 8'h7E : 8'($urandom)));
      run(r % 2 == 1, $sformatf("random %0d", r));
    end

    // R4: count 0 moves 65536 bytes
    cfg_en = '0;
    setch(4, 1, 0, 8'h40, 16'h1234, 1, 0, 3'd4, 16'd0, 8'h00);
    run(1'b0, "count zero R4");

    chk(bad_rd == 0, "R6 no guarded read over all runs", bad_rd, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule